// File: doc/BRIEF.md
# Strobed Serial ADC Result Receiver

This block takes in the serial result stream of an analog-to-digital converter and turns it into parallel words in the system clock domain. Three asynchronous lines arrive: a serial clock, an active-low frame strobe and a serial data line. Each line passes through its own synchronizer chain. The logic then recovers rising edges of the serial clock and the falling edge of the strobe from the synchronized copies.

A frame begins at a strobe fall. The block first expects a fixed number of leading zero bits. It then shifts in the data bits, most significant first, and presents the finished word with a one-cycle valid pulse. If a leading bit is one, the frame is dropped and an error pulse is raised. Serial clock edges outside a frame have no effect, so the serial clock may either run all the time or toggle only during a transfer. A new strobe always restarts framing, even in the middle of a frame.

Top module: `adc_serial_rx`

## Requirements
- R1: After reset `wordValid` is 0, `frameErr` is 0 and `wordOut` is 0.
- R2: The strobe is active low. A falling edge of the synchronized strobe starts a frame. Each serial bit is sampled on a rising edge of the synchronized serial clock that follows that fall.
- R3: The first `LEAD_BITS` bits of a frame (default 2) must be 0. When one of them is 1, `frameErr` pulses high for one cycle, the frame is abandoned and no word is produced for it.
- R4: The next `DATA_BITS` bits (default 14) are data, sent most significant first. The first data bit goes to bit 13 of `wordOut` and the last goes to bit 0. One cycle after the last bit is sampled, `wordOut` shows the word and `wordValid` is high for exactly one cycle.
- R5: `wordOut` changes only in a cycle in which `wordValid` is high. At all other times it holds the last word.
- R6: Serial clock edges before the first strobe, between frames, and after the last data bit produce no word, produce no error, and leave `wordOut` unchanged.
- R7: A strobe fall in the middle of a frame discards the partial word and restarts the bit count. The word that follows is received correctly.
- R8: Frames are received the same way whether the serial clock runs continuously or toggles only during the transfer.
- R9: `wordValid` and `frameErr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclkIn | input | 1 | Serial clock from the converter, asynchronous |
| strbIn | input | 1 | Frame strobe, active low, asynchronous |
| sdataIn | input | 1 | Serial data, asynchronous |
| wordOut | output | DATA_BITS | Last received word |
| wordValid | output | 1 | One-cycle pulse when a new word is on `wordOut` |
| frameErr | output | 1 | One-cycle pulse when a leading bit was 1 |

## Verification
The assertions are evaluated on every cycle and cover four properties. Valid and error pulses last one cycle. They never coincide. The word output holds between valid pulses. Every valid pulse directly follows a detected serial clock rising edge. Only the bench scenarios can show that the received words have the right value and bit order, that leading ones are rejected, that stray edges outside a frame are ignored in both clocking styles, and that a strobe in the middle of a frame restarts cleanly.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_DATA = 2'd2
  } rxState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic capture;
    logic error;
  } ctlStrb_t;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              delayed;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '0;
        delayed <= 1'b0;
      end else begin
        chain   <= {chain[STAGES-2:0], asyncIn[g]};
        delayed <= chain[STAGES-1];
      end
    end
    assign syncOut[g] = chain[STAGES-1];
    assign prevOut[g] = delayed;
  end
endmodule

// File: rtl/adc_rx_ctrl.sv
module adc_rx_ctrl
  import adc_rx_pkg::*;
#(
  parameter int DATA_BITS = 14,
  parameter int LEAD_BITS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     strbFall,
  input  logic     sclkRise,
  input  logic     bitIn,
  output ctlStrb_t ctl
);
  localparam int MAX_BITS = (DATA_BITS > LEAD_BITS) ? DATA_BITS : LEAD_BITS;
  localparam int CNT_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'((LEAD_BITS > 0) ? LEAD_BITS - 1 : 0);
  localparam rxState_t START_ST = (LEAD_BITS == 0) ? ST_DATA : ST_LEAD;

  rxState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextCnt   = cnt;
    if (strbFall) begin
      ctl.clear = 1'b1;
      nextCnt   = '0;
      nextState = START_ST;
    end else if (sclkRise) begin
      case (state)
        ST_LEAD: begin
          if (bitIn) begin
            ctl.error = 1'b1;
            nextState = ST_IDLE;
            nextCnt   = '0;
          end else if (cnt == LEAD_LAST) begin
            nextState = ST_DATA;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == DATA_LAST) begin
            ctl.capture = 1'b1;
            nextState   = ST_IDLE;
            nextCnt     = '0;
          end else begin
            ctl.shift = 1'b1;
            nextCnt   = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end
endmodule

// File: rtl/adc_rx_datapath.sv
module adc_rx_datapath
  import adc_rx_pkg::*;
#(
  parameter int DATA_BITS = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrb_t             ctl,
  input  logic                 bitIn,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic                 frameErr
);
  logic [DATA_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0] nextWord;

  assign nextWord = {shiftReg[DATA_BITS-2:0], bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      wordValid <= ctl.capture;
      frameErr  <= ctl.error;
      if (ctl.clear) begin
        shiftReg <= '0;
      end else if (ctl.shift) begin
        shiftReg <= nextWord;
      end
      if (ctl.capture) begin
        wordOut <= nextWord;
      end
    end
  end
endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx
  import adc_rx_pkg::*;
#(
  parameter int DATA_BITS   = 14,
  parameter int LEAD_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 strbIn,
  input  logic                 sdataIn,
  output logic [DATA_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic                 frameErr
);
  localparam int LINES = 3;

  logic [LINES-1:0] syncNow, syncPrev;
  logic sclkRise, strbFall, bitIn;
  ctlStrb_t ctl;

  adc_rx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({sdataIn, strbIn, sclkIn}),
    .syncOut(syncNow), .prevOut(syncPrev)
  );

  assign sclkRise = syncNow[0] & ~syncPrev[0];
  assign strbFall = ~syncNow[1] & syncPrev[1];
  assign bitIn    = syncNow[2];

  adc_rx_ctrl #(.DATA_BITS(DATA_BITS), .LEAD_BITS(LEAD_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .strbFall(strbFall), .sclkRise(sclkRise),
    .bitIn(bitIn), .ctl(ctl)
  );

  adc_rx_datapath #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIn(bitIn),
    .wordOut(wordOut), .wordValid(wordValid), .frameErr(frameErr)
  );
endmodule

// File: rtl/adc_serial_rx_checker.sv
module adc_serial_rx_checker #(
  parameter int DATA_BITS = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_BITS-1:0] wordOut,
  input logic                 wordValid,
  input logic                 frameErr,
  input logic                 sclkRise
);
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  a_r3_err_single: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && frameErr));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
  a_r2_valid_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(sclkRise));
endmodule

bind adc_serial_rx adc_serial_rx_checker #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .wordOut(wordOut), .wordValid(wordValid),
  .frameErr(frameErr), .sclkRise(sclkRise)
);

// File: tb/adc_serial_rx_tb_top.sv
module adc_serial_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NB = 14;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, strbIn = 1'b1, sdataIn = 1'b0;
  logic [NB-1:0] wordOut;
  logic wordValid, frameErr;

  int tests = 0, fails = 0;
  int validCnt = 0, errCnt = 0, holdViol = 0;
  logic [NB-1:0] lastWord = '0, prevWord = '0;
  bit freeRun = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_rx #(.DATA_BITS(NB), .LEAD_BITS(NL), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .strbIn(strbIn), .sdataIn(sdataIn),
    .wordOut(wordOut), .wordValid(wordValid), .frameErr(frameErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid) begin
        validCnt++;
        lastWord = wordOut;
      end
      if (frameErr) errCnt++;
      if (!wordValid && wordOut != prevWord) holdViol++;
    end
    prevWord = wordOut;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sclkIn = 1'b0;
    sdataIn = b;
    waitClk(HALF);
    sclkIn = 1'b1;
    waitClk(HALF);
  endtask

  task automatic strobe();
    sclkIn = 1'b0;
    strbIn = 1'b0;
    waitClk(2);
    strbIn = 1'b1;
    waitClk(HALF);
  endtask

  task automatic strayBits(input int n, input int seed);
    for (int i = 0; i < n; i++) sendBit(1'((seed >> i) & 1));
  endtask

  task automatic sendFrame(input logic [NB-1:0] w, input logic [NL-1:0] lead);
    if (freeRun) strayBits(3, 5);
    strobe();
    for (int i = NL - 1; i >= 0; i--) sendBit(lead[i]);
    for (int i = NB - 1; i >= 0; i--) sendBit(w[i]);
    if (freeRun) strayBits(5, 27);
    sclkIn = 1'b0;
    waitClk(8);
  endtask

  task automatic goodFrame(input string req, input logic [NB-1:0] w);
    int v0, e0;
    v0 = validCnt;
    e0 = errCnt;
    sendFrame(w, '0);
    check(req, validCnt - v0, 1);
    check(req, int'(lastWord), int'(w));
    check(req, int'(wordOut), int'(w));
    check(req, errCnt - e0, 0);
  endtask

  initial begin
    waitClk(3);
    check("R1 valid", int'(wordValid), 0);
    check("R1 err", int'(frameErr), 0);
    check("R1 word", int'(wordOut), 0);
    rstN = 1'b1;
    waitClk(4);

    // R6: edges before any strobe
    strayBits(20, 32'h5a5a5);
    waitClk(8);
    check("R6 no word before strobe", validCnt, 0);
    check("R6 no err before strobe", errCnt, 0);
    check("R6 word unchanged", int'(wordOut), 0);

    // R4 bit order, gated clock
    freeRun = 0;
    for (int i = 0; i < NB; i++) goodFrame("R4 walking one", NB'(1 << i));
    goodFrame("R4 all ones", '1);
    goodFrame("R4 all zeros", '0);

    // R8 free-running sweep, R6 trailing edges ignored
    freeRun = 1;
    for (int w = 1; w < (1 << NB); w += 331) goodFrame("R8 R6 free sweep", NB'(w));
    freeRun = 0;
    for (int w = 7; w < (1 << NB); w += 1777) goodFrame("R8 gated sweep", NB'(w));

    // R3 leading ones
    for (int p = 1; p < (1 << NL); p++) begin
      int v0, e0;
      logic [NB-1:0] keep;
      v0 = validCnt;
      e0 = errCnt;
      keep = wordOut;
      sendFrame(14'h1234, NL'(p));
      check("R3 error pulse", errCnt - e0, 1);
      check("R3 no word", validCnt - v0, 0);
      check("R3 word kept", int'(wordOut), int'(keep));
    end
    goodFrame("R3 recovery", 14'h2a55);

    // R7 strobe mid-frame
    begin
      int v0;
      v0 = validCnt;
      strobe();
      for (int i = 0; i < NL; i++) sendBit(1'b0);
      for (int i = 0; i < 7; i++) sendBit(1'b1);
      sendFrame(14'h0f0f, '0);
      check("R7 one word", validCnt - v0, 1);
      check("R7 word", int'(lastWord), 16'h0f0f);
    end

    check("R5 hold violations", holdViol, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule